// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block accepts configuration words on a three-wire serial link and holds them in eight 8-bit control registers. Those registers steer a sensor front end downstream: a gain and an offset for each of three colour channels, a mode register and a test register. The link consists of a load strobe, a serial clock and a serial data line. All three are sampled by the system clock through synchronisers, and edges are found after synchronisation, so the serial clock can be slow and asynchronous to the core.

The port listens only while the line-sync input is high. During that time the block drops its output-bus enable, so that the shared pins can be used as inputs. A transfer opens when the strobe falls. Each rising serial clock edge shifts in one bit. When the strobe rises again, the word goes to the register it addresses, provided the full eleven bits arrived. The registers come out of reset with fixed defaults. A reset bit in the mode register restores those defaults. A wake-up from power-down keeps the existing settings but flags the signal-configuration field as stale until that field is written again.

Top module: `cfg_serial_port`

## Requirements
- R1: A word is 11 bits. The first 3 bits sent are the register address, MSB first. The next 8 bits are the data, MSB first. Each bit is taken on a rising edge of `sclk_i`. The word is written when `load_n_i` rises.
- R2: If fewer than 11 serial clock rises fall between the strobe going low and going high again, no register changes.
- R3: Serial clock rises after the eleventh are ignored. The word written is built from the first 11 bits only.
- R4: The address decode is as follows. 0 = red gain, 1 = red offset, 2 = green gain, 3 = green offset, 4 = blue gain, 5 = blue offset, 6 = mode, 7 = test.
- R5: A gain register keeps data bits 7:2 and presents them on a 6-bit port. Data bits 1:0 are discarded.
- R6: After `rst` all gain registers read 0, all offset registers read 8'h40, and the mode and test registers read 0. `cfg_valid_o` reads 1.
- R7: While `line_sync_i` is low, no transfer is received and `bus_oe_o` is 1. While it is high, `bus_oe_o` is 0.
- R8: A write to the mode register with data bit 6 set puts every register back to its R6 value.
- R9: Mode bit 7 is the power-down bit. If a mode write has bit 7 clear while power-down is set, only bit 7 is cleared and the other mode bits keep their values. `cfg_valid_o` then drops to 0.
- R10: A mode write with bit 7 clear while power-down is already clear writes all eight bits and sets `cfg_valid_o` back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sync_i | input | 1 | Line sync. The serial port is active while this is high |
| load_n_i | input | 1 | Load strobe, active low |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| bus_oe_o | output | 1 | Output bus driver enable |
| red_gain_o | output | 6 | Red gain |
| red_offset_o | output | 8 | Red offset |
| grn_gain_o | output | 6 | Green gain |
| grn_offset_o | output | 8 | Green offset |
| blu_gain_o | output | 6 | Blue gain |
| blu_offset_o | output | 8 | Blue offset |
| mode_o | output | 8 | Mode register |
| test_o | output | 8 | Test register |
| cfg_valid_o | output | 1 | Signal-configuration field (mode bits 1:0) is current |

## Verification
The assertions take for granted that each level of the serial clock and the strobe lasts several system clock cycles. They also assume that data is steady across the synchroniser delay around each rising serial clock edge, and that the strobe does not rise in the same window as a clock edge. Under those conditions every edge is seen exactly once, and the data bit is aligned with its clock edge. The stimulus holds each phase for four system clocks. It changes data only while the serial clock is low, and it waits a full phase before raising the strobe. Line sync changes only while the strobe is high.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;
  localparam int WORD_BITS  = ADDR_W + DATA_W;
  localparam int NUM_CHAN   = 3;
  localparam int GAIN_W     = 6;
  localparam logic [DATA_W-1:0] OFFSET_INIT = 8'h40;

  localparam int MODE_PD_BIT  = 7;
  localparam int MODE_RST_BIT = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_RED_GAIN = 3'd0,
    A_RED_OFF  = 3'd1,
    A_GRN_GAIN = 3'd2,
    A_GRN_OFF  = 3'd3,
    A_BLU_GAIN = 3'd4,
    A_BLU_OFF  = 3'd5,
    A_MODE     = 3'd6,
    A_TEST     = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic              strobe_hi_i,
  input  logic              strobe_rise_i,
  input  logic              sclk_rise_i,
  input  logic              sdata_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);

  logic [CNT_W-1:0]     cnt_q;
  logic [WORD_BITS-1:0] shreg_q;
  logic                 full;

  assign full = (cnt_q == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      shreg_q  <= '0;
      commit_o <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
    end else begin
      commit_o <= 1'b0;
      if (active_i && strobe_rise_i && full) begin
        commit_o <= 1'b1;
        addr_o   <= shreg_q[WORD_BITS-1 -: ADDR_W];
        data_o   <= shreg_q[DATA_W-1:0];
      end
      if (!active_i || strobe_hi_i) begin
        cnt_q <= '0;
      end else if (sclk_rise_i && !full) begin
        shreg_q <= {shreg_q[WORD_BITS-2:0], sdata_i};
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  // R3: once eleven bits are held, further clocks leave the word alone
  p_hold_full_r3: assert property (@(posedge clk) disable iff (rst)
    (full && active_i && !strobe_hi_i) |=> $stable(shreg_q));

  // R2: a commit only follows a complete word
  p_commit_full_r2: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(cnt_q) == CNT_FULL);

  // R7: an idle port keeps no partial word
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> cnt_q == '0);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [GAIN_W-1:0] gain_o [NUM_CHAN],
  output logic [DATA_W-1:0] offset_o [NUM_CHAN],
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] test_o,
  output logic              valid_o
);
  logic soft_rst;
  logic chan_hit;
  logic [1:0] chan;

  assign soft_rst = wr_i && (addr_i == A_MODE) && data_i[MODE_RST_BIT];
  assign chan_hit = (addr_i < A_MODE);
  assign chan     = addr_i[2:1];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst || soft_rst) begin
        gain_o[c]   <= '0;
        offset_o[c] <= OFFSET_INIT;
      end else if (wr_i && chan_hit && chan == 2'(c)) begin
        if (addr_i[0]) offset_o[c] <= data_i;
        else           gain_o[c]   <= data_i[DATA_W-1 -: GAIN_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      mode_o  <= '0;
      test_o  <= '0;
      valid_o <= 1'b1;
    end else if (wr_i) begin
      if (addr_i == A_TEST) begin
        test_o <= data_i;
      end else if (addr_i == A_MODE) begin
        if (mode_o[MODE_PD_BIT] && !data_i[MODE_PD_BIT]) begin
          mode_o[MODE_PD_BIT] <= 1'b0;
          valid_o             <= 1'b0;
        end else begin
          mode_o <= data_i;
          if (!data_i[MODE_PD_BIT]) valid_o <= 1'b1;
        end
      end
    end
  end

  // R8: reset bit restores defaults
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (offset_o[0] == OFFSET_INIT) && (mode_o == '0) && valid_o);

  // R9: waking keeps remaining mode bits and marks config stale
  p_wake_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_MODE && !data_i[MODE_RST_BIT] && !data_i[MODE_PD_BIT]
     && mode_o[MODE_PD_BIT])
    |=> !valid_o && $stable(mode_o[MODE_PD_BIT-1:0]) && !mode_o[MODE_PD_BIT]);

  // R5: gain keeps only the upper data bits
  p_gain_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == A_RED_GAIN) |=> gain_o[0] == $past(data_i[DATA_W-1 -: GAIN_W]));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_sync_i,
  input  logic              load_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic              bus_oe_o,
  output logic [GAIN_W-1:0] red_gain_o,
  output logic [DATA_W-1:0] red_offset_o,
  output logic [GAIN_W-1:0] grn_gain_o,
  output logic [DATA_W-1:0] grn_offset_o,
  output logic [GAIN_W-1:0] blu_gain_o,
  output logic [DATA_W-1:0] blu_offset_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] test_o,
  output logic              cfg_valid_o
);
  logic [3:0] raw, synced;
  logic       sync_s, load_s, sclk_s, sdata_s;
  logic       load_d, sclk_d;
  logic       load_rise, sclk_rise;
  logic       wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [GAIN_W-1:0] gain [NUM_CHAN];
  logic [DATA_W-1:0] offset [NUM_CHAN];

  assign raw = {sdata_i, sclk_i, load_n_i, line_sync_i};

  cfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(synced)
  );

  assign {sdata_s, sclk_s, load_s, sync_s} = synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_d   <= 1'b1;
      sclk_d   <= 1'b0;
      bus_oe_o <= 1'b1;
    end else begin
      load_d   <= load_s;
      sclk_d   <= sclk_s;
      bus_oe_o <= !sync_s;
    end
  end

  assign load_rise = load_s && !load_d;
  assign sclk_rise = sclk_s && !sclk_d;

  cfg_shift u_shift (
    .clk(clk), .rst(rst),
    .active_i(sync_s), .strobe_hi_i(load_s), .strobe_rise_i(load_rise),
    .sclk_rise_i(sclk_rise), .sdata_i(sdata_s),
    .commit_o(wr), .addr_o(wr_addr), .data_o(wr_data)
  );

  cfg_regbank u_bank (
    .clk(clk), .rst(rst),
    .wr_i(wr), .addr_i(wr_addr), .data_i(wr_data),
    .gain_o(gain), .offset_o(offset),
    .mode_o(mode_o), .test_o(test_o), .valid_o(cfg_valid_o)
  );

  assign red_gain_o   = gain[0];
  assign grn_gain_o   = gain[1];
  assign blu_gain_o   = gain[2];
  assign red_offset_o = offset[0];
  assign grn_offset_o = offset[1];
  assign blu_offset_o = offset[2];

  // R7: the bus stays released while the port listens
  p_bus_release_r7: assert property (@(posedge clk) disable iff (rst)
    sync_s |=> !bus_oe_o);

  // R7: no write lands on a cycle after the port was idle
  p_no_write_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !sync_s |=> !wr);
endmodule

// File: tb/cfg_serial_port_tb.sv
`timescale 1ns/1ps
module cfg_serial_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_sync = 1'b0, load_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic bus_oe, cfg_valid;
  logic [5:0] rg, gg, bg;
  logic [7:0] ro, go, bo, mode, test;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_serial_port u_dut (
    .clk(clk), .rst(rst), .line_sync_i(line_sync), .load_n_i(load_n),
    .sclk_i(sclk), .sdata_i(sdata), .bus_oe_o(bus_oe),
    .red_gain_o(rg), .red_offset_o(ro), .grn_gain_o(gg), .grn_offset_o(go),
    .blu_gain_o(bg), .blu_offset_o(bo), .mode_o(mode), .test_o(test),
    .cfg_valid_o(cfg_valid)
  );

  // {addr[3], data[8], clocks[5], view[4], expected[8]}
  localparam int NV = 13;
  localparam logic [27:0] VEC [NV] = '{
    {3'd0, 8'hA5, 5'd11, 4'd0, 8'hA4},  // R1 R5 red gain, low bits dropped
    {3'd1, 8'h3C, 5'd11, 4'd1, 8'h3C},  // R4 red offset
    {3'd2, 8'hFF, 5'd11, 4'd2, 8'hFC},  // R5 green gain
    {3'd3, 8'h12, 5'd8,  4'd3, 8'h40},  // R2 short word ignored
    {3'd3, 8'h12, 5'd14, 4'd3, 8'h12},  // R3 extra clocks ignored
    {3'd4, 8'h81, 5'd11, 4'd4, 8'h80},  // R4 blue gain
    {3'd5, 8'h00, 5'd11, 4'd5, 8'h00},  // R4 blue offset
    {3'd7, 8'h2D, 5'd11, 4'd7, 8'h2D},  // R4 test register
    {3'd6, 8'h83, 5'd11, 4'd6, 8'h83},  // R4 mode, power-down set
    {3'd6, 8'h00, 5'd11, 4'd8, 8'h00},  // R9 wake marks config stale
    {3'd0, 8'h00, 5'd11, 4'd6, 8'h03},  // R9 other mode bits kept
    {3'd6, 8'h01, 5'd11, 4'd8, 8'h01},  // R10 config rewritten, valid again
    {3'd1, 8'h3C, 5'd11, 4'd6, 8'h01}   // R10 full mode write took effect
  };

  function automatic logic [7:0] view(input logic [3:0] sel);
    case (sel)
      4'd0: view = {rg, 2'b00};
      4'd1: view = ro;
      4'd2: view = {gg, 2'b00};
      4'd3: view = go;
      4'd4: view = {bg, 2'b00};
      4'd5: view = bo;
      4'd6: view = mode;
      4'd7: view = test;
      default: view = {7'b0, cfg_valid};
    endcase
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] a, input logic [7:0] d, input int nclk);
    logic [10:0] w;
    w = {a, d};
    load_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nclk; i++) begin
      sdata = (i < 11) ? w[10-i] : 1'b1;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    load_n = 1'b1;
    wait_clk(12);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // R6 defaults; R7 bus driven while sync low
    check("R6 red gain", view(0), 8'h00);
    check("R6 red offset", ro, 8'h40);
    check("R6 blue offset", bo, 8'h40);
    check("R6 mode", mode, 8'h00);
    check("R6 test", test, 8'h00);
    check("R6 valid", {7'b0, cfg_valid}, 8'h01);
    check("R7 bus enabled idle", {7'b0, bus_oe}, 8'h01);

    line_sync = 1'b1;
    wait_clk(6);
    check("R7 bus released", {7'b0, bus_oe}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k][27:25], VEC[k][24:17], int'(VEC[k][16:12]));
      check($sformatf("table entry %0d", k), view(VEC[k][11:8]), VEC[k][7:0]);
    end

    // R8 soft reset restores defaults
    send(3'd6, 8'h40, 11);
    check("R8 red offset", ro, 8'h40);
    check("R8 green gain", view(2), 8'h00);
    check("R8 test", test, 8'h00);
    check("R8 mode", mode, 8'h00);
    check("R8 valid", {7'b0, cfg_valid}, 8'h01);

    // R7 no write accepted while sync low
    line_sync = 1'b0;
    wait_clk(6);
    send(3'd1, 8'h55, 11);
    check("R7 write ignored", ro, 8'h40);
    check("R7 bus enabled", {7'b0, bus_oe}, 8'h01);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule